// File: doc/BRIEF.md
# Integer Register File

A bank of general-purpose integer registers for a single-cycle RV32I core. The decoder supplies two source indices and one destination index. The file returns the two source operands combinationally within the same cycle. On the rising clock edge it stores a result into the destination register, but only when the register-write enable is high.

Register x0 is a constant zero. It reads as zero on both ports, and any write aimed at it is dropped. The storage has no reset. The active-low reset input only qualifies the built-in checks, so software must write a register before it relies on its contents.

The depth and width are parameters. The index width is derived from the depth. The write-enable decoder, the storage bank and the two read ports are separate modules.

Top module: `int_regfile`

## Requirements
- R1: The file holds 32 registers, each 32 bits wide. A value written to register k (k = 1..31) reads back unchanged on either read port with index k.
- R2: Both read ports are combinational. A change of a read index changes the matching read data output in the same cycle, with no clock edge in between.
- R3: A write takes place at the rising clock edge when wr_en_i is 1 and wr_idx_i is nonzero. The new value is visible on the read ports after that edge.
- R4: When wr_en_i is 0 at a clock edge, no register changes, whatever wr_idx_i and wr_data_i hold.
- R5: A read with index 0 returns 32'h0 on either port.
- R6: A write with wr_idx_i = 0 has no visible effect. Register 0 still reads 0 and no other register changes.
- R7: Suppose a read index equals the write index in the cycle of a write. Before the edge the port returns the old value, and after the edge it returns the new value.
- R8: Asserting rst_ni low leaves the register contents unchanged.
- R9: The two read ports are independent. They may address the same register or different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the write happens on its rising edge |
| rst_ni | input | 1 | Active-low reset; qualifies the checks only, does not clear storage |
| wr_en_i | input | 1 | Register-write enable |
| wr_idx_i | input | 5 | Destination register index |
| wr_data_i | input | 32 | Data to write |
| rd_a_idx_i | input | 5 | First source register index |
| rd_b_idx_i | input | 5 | Second source register index |
| rd_a_data_o | output | 32 | First source operand |
| rd_b_data_o | output | 32 | Second source operand |

## Verification
The hardest case to reach is a read and a write to the same nonzero register in one cycle. The port must show the old value before the edge and the new value after it, and a design that forwards the write data would hide the difference. To reach this case, every register is first loaded with a distinct value derived from its index. A stimulus vector then sets the read index equal to the write index, and the port is sampled both before and after the edge. A write aimed at x0 carrying all ones, and a reset pulse after all registers hold data, give the other cases that can only be seen from the ports.

// File: rtl/int_regfile_pkg.sv
package int_regfile_pkg;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_XLEN     = 32;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/int_regfile_wr_decode.sv
module int_regfile_wr_decode #(
  parameter int unsigned NUM_REGS = int_regfile_pkg::DEF_NUM_REGS,
  localparam int unsigned IDX_W   = int_regfile_pkg::idx_bits(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  output logic [NUM_REGS-1:0] row_en_o
);
  // entry 0 is never enabled
  assign row_en_o[0] = 1'b0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_row
    assign row_en_o[i] = wr_en_i && (wr_idx_i == IDX_W'(i));
  end

  assert_no_x0_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i == '0) |-> (row_en_o == '0));
  assert_no_write_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (row_en_o == '0));
  assert_single_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_en_o));
endmodule

// File: rtl/int_regfile_bank.sv
module int_regfile_bank #(
  parameter int unsigned NUM_REGS = int_regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned XLEN     = int_regfile_pkg::DEF_XLEN
) (
  input  logic                          clk_i,
  input  logic [NUM_REGS-1:0]           row_en_i,
  input  logic [XLEN-1:0]               wr_data_i,
  output logic [NUM_REGS-1:0][XLEN-1:0] rows_o
);
  assign rows_o[0] = '0;

  // no reset on storage by design
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_row
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i) begin
      if (row_en_i[i]) q <= wr_data_i;
    end
    assign rows_o[i] = q;
  end
endmodule

// File: rtl/int_regfile_rd_port.sv
module int_regfile_rd_port #(
  parameter int unsigned NUM_REGS = int_regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned XLEN     = int_regfile_pkg::DEF_XLEN,
  localparam int unsigned IDX_W   = int_regfile_pkg::idx_bits(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REGS-1:0][XLEN-1:0] rows_i,
  input  logic [IDX_W-1:0]              idx_i,
  output logic [XLEN-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 1; i < NUM_REGS; i++) begin
      if (idx_i == IDX_W'(i)) data_o = rows_i[i];
    end
  end

  assert_x0_reads_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == '0) |-> (data_o == '0));
endmodule

// File: rtl/int_regfile.sv
module int_regfile #(
  parameter int unsigned NUM_REGS = int_regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned XLEN     = int_regfile_pkg::DEF_XLEN,
  localparam int unsigned IDX_W   = int_regfile_pkg::idx_bits(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  output logic [XLEN-1:0]  rd_b_data_o
);
  logic [NUM_REGS-1:0]           row_en;
  logic [NUM_REGS-1:0][XLEN-1:0] rows;

  int_regfile_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .row_en_o (row_en)
  );

  int_regfile_bank #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_bank (
    .clk_i     (clk_i),
    .row_en_i  (row_en),
    .wr_data_i (wr_data_i),
    .rows_o    (rows)
  );

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  data;
    assign idx = (p == 0) ? rd_a_idx_i : rd_b_idx_i;
    int_regfile_rd_port #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rows_i (rows),
      .idx_i  (idx),
      .data_o (data)
    );
  end

  assign rd_a_data_o = g_rd[0].data;
  assign rd_b_data_o = g_rd[1].data;

  assert_write_lands_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != '0) |=>
      (rd_a_idx_i != $past(wr_idx_i) || rd_a_data_o == $past(wr_data_i)));
  assert_write_lands_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != '0) |=>
      (rd_b_idx_i != $past(wr_idx_i) || rd_b_data_o == $past(wr_data_i)));
  assert_hold_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=>
      (rd_a_idx_i != $past(rd_a_idx_i) || rd_a_data_o == $past(rd_a_data_o)));
  assert_ports_agree_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));
endmodule

// File: tb/int_regfile_bench.sv
module int_regfile_bench;
  localparam int N = 32;
  localparam int W = 32;
  localparam int MAX_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] widx = '0, ra = '0, rb = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rda, rdb;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model [N];

  always #2.5 clk = ~clk;

  int_regfile u_int_regfile (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wdata),
    .rd_a_idx_i(ra), .rd_b_idx_i(rb), .rd_a_data_o(rda), .rd_b_data_o(rdb)
  );

  typedef struct packed {
    logic       we;
    logic [4:0] widx;
    logic [W-1:0] wdata;
    logic [4:0] ra;
    logic [4:0] rb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd5,  32'hDEAD_BEEF, 5'd5,  5'd6},
    '{1'b0, 5'd6,  32'h1111_2222, 5'd5,  5'd6},
    '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0},
    '{1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd31},
    '{1'b0, 5'd31, 32'h0BAD_F00D, 5'd31, 5'd1},
    '{1'b1, 5'd1,  32'h0000_0000, 5'd1,  5'd2},
    '{1'b0, 5'd0,  32'h0000_0000, 5'd1,  5'd31},
    '{1'b1, 5'd17, 32'h5A5A_A5A5, 5'd17, 5'd0}
  };

  function automatic logic [W-1:0] pat(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0100_0193;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (we && widx != 0) model[widx] = wdata;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: load every register
    for (int i = 0; i < N; i++) begin
      we = 1'b1; widx = 5'(i); wdata = pat(i);
      tick();
    end
    we = 1'b0;
    for (int i = 0; i < N; i++) begin
      ra = 5'(i); rb = 5'(N - 1 - i);
      #0.5;
      check(rda, model[i], (i == 0) ? "R5" : "R1");
      check(rdb, model[N-1-i], "R1");
    end
    // R2: index change with no edge in between
    @(negedge clk);
    ra = 5'd3; #0.5; check(rda, pat(3), "R2");
    ra = 5'd4; #0.5; check(rda, pat(4), "R2");

    // vector table: sample before the edge, then clock
    for (int v = 0; v < NV; v++) begin
      we = VEC[v].we; widx = VEC[v].widx; wdata = VEC[v].wdata;
      ra = VEC[v].ra; rb = VEC[v].rb;
      #0.5;
      check(rda, model[ra], (we && widx == ra && widx != 0) ? "R7" : "R9");
      check(rdb, model[rb], (rb == 0) ? "R5" : "R9");
      tick();
      check(rda, model[ra], we ? "R3" : "R4");
      check(rdb, model[rb], (we && widx == 0) ? "R6" : "R9");
    end

    // R6: write of all ones to index 0 leaves everything unchanged
    we = 1'b1; widx = 5'd0; wdata = '1;
    tick();
    we = 1'b0;
    for (int i = 0; i < N; i++) begin
      ra = 5'(i); rb = 5'd0; #0.5;
      check(rda, model[i], "R6");
      check(rdb, '0, "R6");
    end

    // R8: reset pulse keeps contents
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    for (int i = 0; i < N; i++) begin
      ra = 5'(i); rb = 5'(i); #0.5;
      check(rda, model[i], "R8");
      check(rdb, model[i], "R8");
    end
    finish_run();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule